// File: doc/BRIEF.md
# Power-Gated Byte-Wide SRAM Array

A byte-wide static memory with an active-low control interface (chip enable, output enable, write enable). The control pins are sampled on a fast system clock, so every pin change takes effect at the next rising clock edge. The byte lanes are modelled as a separate data output and a drive-enable flag. A low `dout_en` stands for the pins floating.

A supervisor drives `pwr_ok`. While it is low, the memory is write-protected. Every control, address and data input is then ignored and the outputs float. The stored bytes are kept through protection and through reset, so a power cycle can be checked for retention.

The address port is 19 bits wide. The storage holds `DEPTH` bytes (a parameter kept small for simulation) and is indexed by the low address bits. After every write, the chip or write enable must stay high for a set number of clock samples before the next write may open. An early reopening raises a one-cycle violation flag.

Top module: `pg_byte_sram`

## Requirements
- R1: When a clock edge samples `pwr_ok`=1, `we_n`=1, `ce_n`=0 and `oe_n`=0, then from that edge `dout_en`=1 and `dout` shows the byte stored at `addr` modulo `DEPTH`. The storage index is the low log2(`DEPTH`) bits of the 19-bit address, so addresses 0x7FFFF and 0x003FF name the same byte when `DEPTH`=1024.
- R2: When an edge samples `ce_n`=1 or `oe_n`=1, then from that edge `dout_en`=0 and `dout`=0.
- R3: A write window is open while edges sample `ce_n`=0, `we_n`=0 and `pwr_ok`=1. While the window is open, `dout_en`=0 and `dout`=0, even with `oe_n` low. This includes the case where a read was under way when `we_n` fell.
- R4: A write commits at the first edge that samples `ce_n` or `we_n` high after the window was open. It stores the address and data taken at the last edge inside the window. Data present earlier in the window is overwritten, and the stored byte can be read from the following edge.
- R5: The window opens at whichever falling edge of `ce_n` and `we_n` comes later, in either order. It closes at whichever of the two rises first.
- R6: After a write commits, the window must stay closed for at least `REC_CYC` consecutive edges. A window that opens earlier makes `rec_viol` high for exactly one cycle, starting at the edge that samples the opening. A reopening after `REC_CYC` closed edges leaves `rec_viol` at 0.
- R7: An edge that samples `pwr_ok`=0 treats all other inputs as inactive, so `dout_en`=0 and `dout`=0 from that edge. A write window that is open when protection arrives is dropped without storing anything.
- R8: Stored bytes survive a period with `pwr_ok`=0 and an assertion of `rst_n`.
- R9: While `rst_n` is low and after its release with idle pins, `dout_en`=0, `dout`=0 and `rec_viol`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sample state (not the storage) |
| pwr_ok | input | 1 | Supervisor power-good; low write-protects and floats outputs |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 19 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0 when not driven |
| dout_en | output | 1 | High when the data pins would be driven |
| rec_viol | output | 1 | One-cycle pulse on a write opened inside the recovery interval |

## Verification
Writes are opened in both enable orders and closed by either enable rising first. This shows that the window is framed by the later fall and the earlier rise. It also shows that the last sampled data wins over data changed mid-window. Reads with `oe_n` held low across a falling `we_n` separate a read cycle from a write cycle. A pair of aliased addresses confirms the index width. Reopening a write one sample early and then exactly on the boundary separates a violating recovery from a legal one. Dropping `pwr_ok` inside an open window, followed by later reads and a reset, shows both the aborted write and the retained contents.

// File: rtl/pg_byte_sram.sv
module pg_byte_sram #(
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 1024,
  parameter int REC_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              rec_viol
);
  localparam int IW  = $clog2(DEPTH);
  localparam int RCW = $clog2(REC_CYC + 1);

  logic [DATA_W-1:0] mem [DEPTH];

  logic              s_ce, s_oe, s_we;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_din;
  logic [RCW-1:0]    rcnt;

  wire g_ce   = ce_n | ~pwr_ok;
  wire g_oe   = oe_n | ~pwr_ok;
  wire g_we   = we_n | ~pwr_ok;
  wire wr_now = ~g_ce & ~g_we;
  wire wr_cur = ~s_ce & ~s_we;
  wire commit = wr_cur & ~wr_now & pwr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ce   <= 1'b1;
      s_oe   <= 1'b1;
      s_we   <= 1'b1;
      s_addr <= '0;
      s_din  <= '0;
    end else begin
      s_ce <= g_ce;
      s_oe <= g_oe;
      s_we <= g_we;
      if (pwr_ok) begin
        s_addr <= addr;
        s_din  <= din;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit) mem[s_addr[IW-1:0]] <= s_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt     <= '0;
      rec_viol <= 1'b0;
    end else begin
      rec_viol <= wr_now & ~wr_cur & (rcnt != '0);
      if (commit)           rcnt <= RCW'(REC_CYC - 1);
      else if (rcnt != '0)  rcnt <= rcnt - 1'b1;
    end
  end

  assign dout_en = ~s_ce & ~s_oe & s_we;
  assign dout    = dout_en ? mem[s_addr[IW-1:0]] : '0;

  a_r1_read_needs_pins: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> ($past(pwr_ok) && $past(we_n) && !$past(ce_n) && !$past(oe_n)));

  a_r2_float_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> dout == '0);

  a_r3_quiet_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_ok) && !$past(ce_n) && !$past(we_n)) |-> !dout_en);

  a_r6_viol_on_open: assert property (@(posedge clk) disable iff (!rst_n)
    rec_viol |-> ($past(pwr_ok) && !$past(ce_n) && !$past(we_n)));

  a_r6_viol_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rec_viol |=> !rec_viol);

  a_r7_protect_floats: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pwr_ok) |-> !dout_en);
endmodule

// File: tb/pg_byte_sram_tb.sv
module pg_byte_sram_tb;
  localparam int DEPTH = 1024;
  localparam int REC   = 4;

  logic        clk = 0, rst_n = 0, pwr_ok = 0;
  logic        ce_n = 1, oe_n = 1, we_n = 1;
  logic [18:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_en, rec_viol;

  int checks = 0, errors = 0;
  bit done = 0;

  pg_byte_sram #(.DEPTH(DEPTH), .REC_CYC(REC)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .rec_viol(rec_viol));

  always #2 clk = ~clk;

  // behavioural reference, evaluated on every rising edge
  int mm [int];
  bit p_ce = 1, p_oe = 1, p_we = 1;
  int p_addr = 0, p_din = 0, rc = 0;
  bit e_en = 0, e_viol = 0;
  int e_dout = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      p_ce = 1; p_oe = 1; p_we = 1; rc = 0;
      e_en = 0; e_viol = 0; e_dout = 0;
    end else begin
      bit c_ce, c_oe, c_we, open_now, open_prev;
      c_ce = ce_n || !pwr_ok;
      c_oe = oe_n || !pwr_ok;
      c_we = we_n || !pwr_ok;
      open_now  = !c_ce && !c_we;
      open_prev = !p_ce && !p_we;
      e_viol = open_now && !open_prev && rc > 0;
      if (open_prev && !open_now && pwr_ok) begin
        mm[p_addr % DEPTH] = p_din;
        rc = REC - 1;
      end else if (rc > 0) rc--;
      p_ce = c_ce; p_oe = c_oe; p_we = c_we;
      if (pwr_ok) begin p_addr = int'(addr); p_din = int'(din); end
      e_en = !p_ce && !p_oe && p_we;
      e_dout = (e_en && mm.exists(p_addr % DEPTH)) ? mm[p_addr % DEPTH] : 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      string t;
      t = !pwr_ok ? "R7 outputs" : (!p_ce && !p_we) ? "R3 outputs" : e_en ? "R1 outputs" : "R2 outputs";
      chk(dout_en == e_en, {t, " dout_en"}, dout_en, e_en);
      chk(int'(dout) == e_dout, {t, " dout"}, dout, e_dout);
      chk(rec_viol == e_viol, "R6 rec_viol", rec_viol, e_viol);
    end
  end

  task automatic idle(input int n);
    ce_n = 1; oe_n = 1; we_n = 1;
    repeat (n) @(negedge clk);
  endtask

  // window by we_n inside ce_n, closed by we_n rising; two data values, last wins
  task automatic wr(input int a, input int d);
    addr = 19'(a); din = 8'(d ^ 8'hFF); ce_n = 0; oe_n = 1; we_n = 1;
    @(negedge clk); we_n = 0;
    @(negedge clk); din = 8'(d);
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1;
    repeat (REC) @(negedge clk);
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    addr = 19'(a); ce_n = 0; oe_n = 0; we_n = 1;
    @(negedge clk);
    chk(dout_en == 1 && int'(dout) == exp, tag, dout, exp);
    idle(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(dout_en == 0 && dout == 0 && rec_viol == 0, "R9 reset held", {dout_en, dout, rec_viol}, 0);
    rst_n = 1; pwr_ok = 1;
    idle(2);
    chk(dout_en == 0 && dout == 0 && rec_viol == 0, "R9 after release", {dout_en, dout, rec_viol}, 0);

    wr(19'h00010, 8'hA5);
    rd(19'h00010, 8'hA5, "R4 last sampled data stored");
    wr(19'h7FFFF, 8'h3C);
    rd(19'h003FF, 8'h3C, "R1 aliased address read");

    // R5: we_n falls first, ce_n later; closed by ce_n rising first
    addr = 19'h00020; din = 8'h11; we_n = 0; ce_n = 1; oe_n = 1;
    @(negedge clk); ce_n = 0;
    @(negedge clk); din = 8'h5A;
    @(negedge clk); ce_n = 1;
    @(negedge clk); we_n = 1;
    repeat (REC) @(negedge clk);
    rd(19'h00020, 8'h5A, "R5 reverse order window");

    // R3: read under way, then we_n falls with oe_n still low
    addr = 19'h00010; ce_n = 0; oe_n = 0; we_n = 1;
    @(negedge clk);
    chk(dout_en == 1 && dout == 8'hA5, "R1 read before write", dout, 8'hA5);
    din = 8'h77; we_n = 0;
    @(negedge clk);
    chk(dout_en == 0 && dout == 0, "R3 outputs off in write", {dout_en, dout}, 0);
    we_n = 1;
    @(negedge clk);
    chk(dout_en == 1 && dout == 8'h77, "R4 read right after commit", dout, 8'h77);
    idle(REC);

    // R2: ce_n or oe_n high floats outputs
    addr = 19'h00010; ce_n = 1; oe_n = 0; we_n = 1;
    @(negedge clk);
    chk(dout_en == 0 && dout == 0, "R2 ce_n high", {dout_en, dout}, 0);
    ce_n = 0; oe_n = 1;
    @(negedge clk);
    chk(dout_en == 0 && dout == 0, "R2 oe_n high", {dout_en, dout}, 0);
    idle(REC);

    // R6: early reopen flags, boundary reopen does not
    addr = 19'h00030; din = 8'h01; ce_n = 0; we_n = 0;
    @(negedge clk); we_n = 1;
    @(negedge clk); we_n = 0; din = 8'h02;
    @(negedge clk);
    chk(rec_viol == 1, "R6 early reopen flagged", rec_viol, 1);
    we_n = 1;
    repeat (REC) @(negedge clk);
    we_n = 0; din = 8'h03;
    @(negedge clk);
    chk(rec_viol == 0, "R6 boundary reopen clean", rec_viol, 0);
    we_n = 1;
    @(negedge clk); ce_n = 1;
    repeat (REC) @(negedge clk);
    rd(19'h00030, 8'h03, "R6 write still performed");

    // R7: protect inside open window aborts the write
    addr = 19'h00040; din = 8'hEE; ce_n = 0; oe_n = 0; we_n = 0;
    @(negedge clk); pwr_ok = 0; addr = 19'h00010;
    @(negedge clk);
    chk(dout_en == 0 && dout == 0, "R7 outputs float", {dout_en, dout}, 0);
    we_n = 1; din = 8'h99;
    @(negedge clk);
    chk(dout_en == 0, "R7 read ignored", dout_en, 0);
    ce_n = 1; oe_n = 1;
    repeat (3) @(negedge clk);
    pwr_ok = 1;
    idle(REC);
    rd(19'h00010, 8'h77, "R7 no write while protected");

    // R8: retention across protect and reset
    pwr_ok = 0; idle(5); pwr_ok = 1; idle(2);
    rd(19'h00020, 8'h5A, "R8 retained after protect");
    rst_n = 0; idle(3); rst_n = 1; idle(2);
    rd(19'h003FF, 8'h3C, "R8 retained after reset");
    rd(19'h00040 - 19'h20, 8'h5A, "R7 aborted write left no trace elsewhere");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule